// File: doc/BRIEF.md
# Virtual-Machine Arithmetic Execute Stage

This block is the arithmetic stage of a 64-bit register virtual machine. Each cycle it can take one 64-bit instruction word along with the current values of the destination and source registers. It decodes the word, runs one integer arithmetic or logic operation and, one clock later, presents three things: the value to write back, the index of the destination register, and a write strobe. Instructions enter and leave under a valid/ready handshake, so a stalled consumer holds the stage without losing data.

A single table of operation codes serves two operand classes. The narrow class works on the low 32 bits of each operand, and the wide class works on all 64 bits. The second operand is either the source register or a 32-bit immediate carried in the instruction word. The stage does not handle loads, stores, branches or byte-order conversion. An instruction it cannot execute comes out flagged as illegal and writes nothing.

Top module: `vmx_alu_exec`

## Requirements
- R1: An instruction is accepted on a clock edge where `in_valid` and `in_ready` are both high, and its result appears with `out_valid` high right after that edge. `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. While the output is stalled, every output holds its value.
- R2: Instruction word fields: destination index in bits 11:8, source index in bits 15:12, immediate in bits 63:32, operation in bits 7:4, operand select in bit 3 and class in bits 2:0. Bit 3 = 1 takes the second operand from `src_val`, and bit 3 = 0 takes it from the immediate. `out_rd` always carries bits 11:8.
- R3: Class 3'b100 (narrow): both operands are cut to their low 32 bits before the operation, and the 32-bit result is zero-extended to 64 bits.
- R4: Class 3'b111 (wide): the operation uses full 64-bit operands. In immediate mode the immediate is sign-extended to 64 bits.
- R5: Operation codes 0x0 add, 0x1 subtract, 0x2 multiply (low half), 0x4 or, 0x5 and, 0xa xor, and 0xb move (the result is the second operand).
- R6: 0x6 is a left shift and 0x7 is a logical right shift. The shift amount is the second operand masked to 5 bits in the narrow class and to 6 bits in the wide class.
- R7: 0xc is an arithmetic right shift that copies the sign bit: bit 31 in the narrow class, bit 63 in the wide class. It uses the same amount masking as R6.
- R8: 0x3 is an unsigned divide. A divide by zero gives 0.
- R9: 0x9 is an unsigned remainder. A remainder by zero gives the destination operand unchanged (in the narrow class, its low 32 bits zero-extended).
- R10: 0x8 gives the two's-complement negation of the destination operand. The second operand is ignored.
- R11: Operation codes 0xd, 0xe and 0xf, and any class other than 3'b100 and 3'b111, produce `out_illegal` = 1, `out_we` = 0 and `out_result` = 0. Every legal instruction produces `out_we` = 1 and `out_illegal` = 0.
- R12: A synchronous active-high reset clears `out_valid`.
- R13: The offset field (bits 31:16) and the source index field have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present |
| in_ready | output | 1 | Stage can take an instruction |
| instr | input | 64 | Instruction word |
| dst_val | input | 64 | Current value of the destination register |
| src_val | input | 64 | Current value of the source register |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Value to write back |
| out_rd | output | 4 | Destination register index |
| out_we | output | 1 | Write-back strobe |
| out_illegal | output | 1 | Instruction could not be executed |

## Verification
The bench sweeps every operation code in both classes and both operand sources over operand patterns chosen to break narrow handling. One pattern carries junk in the upper halves: if the operands are not truncated, the narrow class leaks that junk into the result. Another makes a 32-bit sum overflow: if the result is not zero-extended, the carry shows up in bit 32. Shift amounts of 65 and 33 expose missing masking, and negative operands expose an arithmetic shift that reads the wrong sign bit or a narrow immediate that gets sign-extended. Directed cases cover divide and remainder by zero, every unused class value, and a stalled output that a wrongly designed stage would overwrite or drop.

// File: rtl/vmx_pkg.sv
package vmx_pkg;
  localparam int unsigned XLEN   = 64;
  localparam int unsigned HLEN   = XLEN / 2;
  localparam int unsigned RIDX_W = 4;
  localparam int unsigned SH_W   = $clog2(XLEN);

  localparam logic [2:0] CLS_NARROW = 3'b100;
  localparam logic [2:0] CLS_WIDE   = 3'b111;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0, OP_SUB  = 4'h1, OP_MUL  = 4'h2, OP_DIV = 4'h3,
    OP_OR   = 4'h4, OP_AND  = 4'h5, OP_SHL  = 4'h6, OP_SHR = 4'h7,
    OP_NEG  = 4'h8, OP_REM  = 4'h9, OP_XOR  = 4'ha, OP_MOV = 4'hb,
    OP_SAR  = 4'hc, OP_SWAP = 4'hd, OP_RSVE = 4'he, OP_RSVF = 4'hf
  } op_e;

  typedef struct packed {
    op_e               op;
    logic              narrow;
    logic              use_reg;
    logic [RIDX_W-1:0] rd;
    logic [HLEN-1:0]   imm;
    logic              legal;
  } dec_t;
endpackage

// File: rtl/vmx_decode.sv
module vmx_decode
  import vmx_pkg::*;
(
  input  logic [7:0]        opcode,
  input  logic [RIDX_W-1:0] rd_field,
  input  logic [HLEN-1:0]   imm_field,
  output dec_t              dec
);
  logic cls_ok;
  logic op_ok;

  always_comb begin
    cls_ok = (opcode[2:0] == CLS_NARROW) || (opcode[2:0] == CLS_WIDE);
    op_ok  = (opcode[7:4] <= 4'hc);
    dec.op      = op_e'(opcode[7:4]);
    dec.narrow  = (opcode[2:0] == CLS_NARROW);
    dec.use_reg = opcode[3];
    dec.rd      = rd_field;
    dec.imm     = imm_field;
    dec.legal   = cls_ok && op_ok;
  end
endmodule

// File: rtl/vmx_operands.sv
module vmx_operands
  import vmx_pkg::*;
(
  input  dec_t            dec,
  input  logic [XLEN-1:0] dst_val,
  input  logic [XLEN-1:0] src_val,
  output logic [XLEN-1:0] opa,
  output logic [XLEN-1:0] opb
);
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] b_raw;

  always_comb begin
    imm_ext = dec.narrow ? {{(XLEN-HLEN){1'b0}}, dec.imm}
                         : {{(XLEN-HLEN){dec.imm[HLEN-1]}}, dec.imm};
    b_raw   = dec.use_reg ? src_val : imm_ext;
    opa     = dec.narrow ? {{(XLEN-HLEN){1'b0}}, dst_val[HLEN-1:0]} : dst_val;
    opb     = dec.narrow ? {{(XLEN-HLEN){1'b0}}, b_raw[HLEN-1:0]} : b_raw;
  end
endmodule

// File: rtl/vmx_alu_core.sv
module vmx_alu_core
  import vmx_pkg::*;
(
  input  op_e             op,
  input  logic            narrow,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic [XLEN-1:0] res
);
  logic [SH_W-1:0] shamt;
  logic [XLEN-1:0] a_sx;
  logic [XLEN-1:0] raw;

  always_comb begin
    shamt = narrow ? {1'b0, opb[SH_W-2:0]} : opb[SH_W-1:0];
    a_sx  = narrow ? {{(XLEN-HLEN){opa[HLEN-1]}}, opa[HLEN-1:0]} : opa;
    unique case (op)
      OP_ADD:  raw = opa + opb;
      OP_SUB:  raw = opa - opb;
      OP_MUL:  raw = opa * opb;
      OP_DIV:  raw = (opb == '0) ? '0 : opa / opb;
      OP_OR:   raw = opa | opb;
      OP_AND:  raw = opa & opb;
      OP_SHL:  raw = opa << shamt;
      OP_SHR:  raw = opa >> shamt;
      OP_NEG:  raw = '0 - opa;
      OP_REM:  raw = (opb == '0) ? opa : opa % opb;
      OP_XOR:  raw = opa ^ opb;
      OP_MOV:  raw = opb;
      OP_SAR:  raw = $unsigned($signed(a_sx) >>> shamt);
      default: raw = '0;
    endcase
    res = narrow ? {{(XLEN-HLEN){1'b0}}, raw[HLEN-1:0]} : raw;
  end
endmodule

// File: rtl/vmx_alu_exec.sv
module vmx_alu_exec
  import vmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [XLEN-1:0]   instr,
  input  logic [XLEN-1:0]   dst_val,
  input  logic [XLEN-1:0]   src_val,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XLEN-1:0]   out_result,
  output logic [RIDX_W-1:0] out_rd,
  output logic              out_we,
  output logic              out_illegal
);
  dec_t            dec;
  logic [XLEN-1:0] opa;
  logic [XLEN-1:0] opb;
  logic [XLEN-1:0] alu_res;
  logic            accept;

  vmx_decode u_dec (
    .opcode    (instr[7:0]),
    .rd_field  (instr[11:8]),
    .imm_field (instr[XLEN-1:XLEN-HLEN]),
    .dec       (dec)
  );

  vmx_operands u_opnd (
    .dec     (dec),
    .dst_val (dst_val),
    .src_val (src_val),
    .opa     (opa),
    .opb     (opb)
  );

  vmx_alu_core u_core (
    .op     (dec.op),
    .narrow (dec.narrow),
    .opa    (opa),
    .opb    (opb),
    .res    (alu_res)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_rd      <= '0;
      out_we      <= 1'b0;
      out_illegal <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_result  <= dec.legal ? alu_res : '0;
      out_rd      <= dec.rd;
      out_we      <= dec.legal;
      out_illegal <= !dec.legal;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/vmx_alu_exec_chk.sv
module vmx_alu_exec_chk
  import vmx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [XLEN-1:0]   instr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [XLEN-1:0]   out_result,
  input logic [RIDX_W-1:0] out_rd,
  input logic              out_we,
  input logic              out_illegal
);
  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R1
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_rd) && $stable(out_we))); // R1
  AST_RD_ROUTED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_rd == $past(instr[11:8]))); // R2
  AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && instr[2:0] == CLS_NARROW) |=> (out_result[XLEN-1:HLEN] == '0)); // R3
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (!out_we && out_result == '0)); // R11
  AST_WE_XOR_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_we != out_illegal)); // R11
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !out_valid); // R12
endmodule

bind vmx_alu_exec vmx_alu_exec_chk u_chk (.*);

// File: tb/vmx_alu_exec_tb.sv
module vmx_alu_exec_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] instr = '0;
  logic [63:0] dst_val = '0;
  logic [63:0] src_val = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic [3:0]  out_rd;
  logic        out_we;
  logic        out_illegal;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  vmx_alu_exec u_dut (.*);

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h6, 4'h7: return "R6";
      4'hc:       return "R7";
      4'h3:       return "R8";
      4'h9:       return "R9";
      4'h8:       return "R10";
      4'hd, 4'he, 4'hf: return "R11";
      default:    return "R5";
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [63:0] ins, input logic [63:0] d, input logic [63:0] s);
    logic        nar;
    logic [63:0] a, b, r, asx;
    int          sh;
    nar = (ins[2:0] == 3'b100);
    if (!(nar || ins[2:0] == 3'b111) || ins[7:4] > 4'hc) return 64'd0;
    a = nar ? (d & 64'hFFFF_FFFF) : d;
    if (ins[3]) b = s;
    else if (nar) b = {32'd0, ins[63:32]};
    else b = {{32{ins[63]}}, ins[63:32]};
    if (nar) b = b & 64'hFFFF_FFFF;
    sh  = nar ? int'(b % 32) : int'(b % 64);
    asx = nar ? {{32{a[31]}}, a[31:0]} : a;
    case (ins[7:4])
      4'h0: r = a + b;
      4'h1: r = a - b;
      4'h2: r = a * b;
      4'h3: r = (b == 0) ? 64'd0 : a / b;
      4'h4: r = a | b;
      4'h5: r = a & b;
      4'h6: r = a << sh;
      4'h7: r = a >> sh;
      4'h8: r = ~a + 64'd1;
      4'h9: r = (b == 0) ? a : a % b;
      4'ha: r = a ^ b;
      4'hb: r = b;
      default: r = $unsigned($signed(asx) >>> sh);
    endcase
    if (nar) r = r & 64'hFFFF_FFFF;
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [63:0] ins, input logic [63:0] d, input logic [63:0] s);
    @(negedge clk);
    instr = ins; dst_val = d; src_val = s; in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_and_check(input string tag, input logic [63:0] ins,
                               input logic [63:0] d, input logic [63:0] s, input logic [63:0] exp);
    logic legal;
    legal = (ins[2:0] == 3'b100 || ins[2:0] == 3'b111) && ins[7:4] <= 4'hc;
    issue(ins, d, s);
    check({tag, " R1 valid"}, {63'd0, out_valid}, 64'd1);
    check({tag, " R2 rd"}, {60'd0, out_rd}, {60'd0, ins[11:8]});
    check({tag, " R11 we"}, {63'd0, out_we}, {63'd0, legal});
    check({tag, " R11 illegal"}, {63'd0, out_illegal}, {63'd0, !legal});
    check(tag, out_result, exp);
  endtask

  function automatic logic [63:0] mk(input logic [31:0] imm, input logic [15:0] off,
                                     input logic [3:0] rs, input logic [3:0] rd, input logic [7:0] opc);
    return {imm, off, rs, rd, opc};
  endfunction

  logic [63:0] pd [6] = '{64'h0, 64'h1, 64'h8000_0000_0000_0001, 64'h1234_5678_9abc_def0,
                           64'hFFFF_FFFF_FFFF_FFFB, 64'hDEAD_BEEF_FFFF_FFFF};
  logic [63:0] ps [6] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0003, 64'h0fed_cba9_8765_4321,
                           64'h0000_0000_0000_0041, 64'h0000_0001_0000_0021};
  logic [31:0] pi [6] = '{32'h0, 32'hFFFF_FFF0, 32'h0000_0041, 32'h8000_0000, 32'h0000_0003, 32'h7FFF_FFFF};

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 reset valid", {63'd0, out_valid}, 64'd0);
    check("R1 ready after reset", {63'd0, in_ready}, 64'd1);
    rst = 1'b0;

    // Sweep: every op, both classes, both sources, several patterns
    for (int op = 0; op < 16; op++)
      for (int c = 0; c < 2; c++)
        for (int m = 0; m < 2; m++)
          for (int p = 0; p < 6; p++) begin
            logic [63:0] ins;
            ins = mk(pi[p], 16'h0, 4'(p), 4'(op), {4'(op), m[0], (c == 0) ? 3'b100 : 3'b111});
            run_and_check(tag_of(4'(op)), ins, pd[p], ps[p], model(ins, pd[p], ps[p]));
          end

    // Every other class value is illegal
    for (int c = 0; c < 8; c++) begin
      if (c == 4 || c == 7) continue;
      run_and_check("R11 class", mk(32'h5, 16'h0, 4'h1, 4'h2, {4'h0, 1'b1, 3'(c)}),
                    64'h5, 64'h7, 64'd0);
    end

    // Directed values computed by hand
    run_and_check("R3 narrow add wrap", mk(0, 0, 1, 3, 8'h0C), 64'hAAAA_AAAA_FFFF_FFFF, 64'h5555_5555_0000_0001, 64'd0);
    run_and_check("R3 narrow imm not sext", mk(32'hFFFF_FFFF, 0, 0, 3, 8'hB4), 64'h0, 64'h0, 64'h0000_0000_FFFF_FFFF);
    run_and_check("R4 wide imm sext", mk(32'hFFFF_FFFF, 0, 0, 3, 8'h07), 64'h5, 64'h0, 64'h4);
    run_and_check("R6 wide shl masked 65", mk(0, 0, 1, 3, 8'h6F), 64'h3, 64'd65, 64'h6);
    run_and_check("R6 narrow shr masked 33", mk(0, 0, 1, 3, 8'h7C), 64'h8000_0000, 64'd33, 64'h4000_0000);
    run_and_check("R7 narrow sar sign31", mk(0, 0, 1, 3, 8'hCC), 64'h0000_0000_8000_0000, 64'd4, 64'h0000_0000_F800_0000);
    run_and_check("R7 wide sar sign63", mk(0, 0, 1, 3, 8'hCF), 64'h8000_0000_0000_0000, 64'd60, 64'hFFFF_FFFF_FFFF_FFF8);
    run_and_check("R8 div by zero", mk(0, 0, 1, 3, 8'h3F), 64'h1234, 64'h0, 64'h0);
    run_and_check("R8 div unsigned", mk(0, 0, 1, 3, 8'h3F), 64'hFFFF_FFFF_FFFF_FFFE, 64'h2, 64'h7FFF_FFFF_FFFF_FFFF);
    run_and_check("R9 rem by zero wide", mk(0, 0, 1, 3, 8'h9F), 64'hCAFE_0000_1234, 64'h0, 64'hCAFE_0000_1234);
    run_and_check("R9 rem by zero narrow", mk(0, 0, 1, 3, 8'h9C), 64'hCAFE_0000_1234, 64'h1_0000_0000, 64'h1234);
    run_and_check("R10 neg", mk(32'h7, 0, 0, 3, 8'h87), 64'h5, 64'h9, 64'hFFFF_FFFF_FFFF_FFFB);
    run_and_check("R11 swap op", mk(0, 0, 1, 3, 8'hDF), 64'h1, 64'h2, 64'h0);

    // Offset and source index have no effect
    run_and_check("R13 offset a", mk(32'h10, 16'h0000, 4'h0, 4'h5, 8'h07), 64'h20, 64'h99, 64'h30);
    run_and_check("R13 offset b", mk(32'h10, 16'hBEEF, 4'hF, 4'h5, 8'h07), 64'h20, 64'h99, 64'h30);

    // Backpressure: stalled output is held, new input blocked
    @(negedge clk);
    out_ready = 1'b0;
    issue(mk(0, 0, 1, 4'h6, 8'h0F), 64'd10, 64'd20);
    check("R1 stall result", out_result, 64'd30);
    check("R1 stall blocks ready", {63'd0, in_ready}, 64'd0);
    instr = mk(0, 0, 1, 4'h9, 8'h1F); dst_val = 64'd50; src_val = 64'd8; in_valid = 1'b1;
    @(negedge clk);
    check("R1 stall held", out_result, 64'd30);
    check("R1 stall rd held", {60'd0, out_rd}, 64'd6);
    out_ready = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check("R1 second after release", out_result, 64'd42);
    check("R1 second rd", {60'd0, out_rd}, 64'd9);
    @(negedge clk);
    check("R1 drains", {63'd0, out_valid}, 64'd0);

    // Reset mid-stream clears valid
    issue(mk(0, 0, 1, 1, 8'h0F), 1, 1);
    rst = 1'b1;
    @(negedge clk);
    check("R12 reset clears", {63'd0, out_valid}, 64'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule